// File: doc/BRIEF.md
# Trigger Acceptance and Event Bookkeeping

This block sits behind a command decoder and keeps a detector module's trigger stream in step with its event data. It receives one-cycle pulses for a trigger, a bunch-counter reset and an event-counter reset. From these it keeps a free-running bunch-crossing number and a trigger identifier, and it decides for every trigger whether an event slot is free.

When a trigger is accepted, a 16-bit record is queued in a 16-entry event queue. The record holds the number of triggers lost since the previous record, the low bits of the trigger identifier and the bunch-crossing number. A downstream event builder drains the queue with read strobes. When the queue is full, triggers are dropped but counted. If a trigger lands when only one slot remains, its record is held back until the next read, so that the record carries every loss up to that read.

A configurable burst length lets several consecutive triggers share one identifier. Each trigger in a burst is still its own event, with its own bunch-crossing number.

Top module: `l1_trigger_keeper`

## Requirements
- R1: `bcid_o` increases by one (mod 256) on every clock edge after reset. A cycle with `bcr_i` high makes it 0 on the following edge.
- R2: A trigger that starts a burst (no burst window open) increments `l1id_o` by one on the next edge, whether it is accepted or dropped. It also opens a window of `contig_i` further cycles.
- R3: A trigger inside an open window leaves `l1id_o` unchanged. Its record carries the same identifier as the trigger that opened the window. With `contig_i` = k, a burst spans up to k+1 triggers.
- R4: `pend_o` counts accepted events not yet read. It rises by one per accepted trigger and falls by one per effective read, never exceeds 16, and is unchanged when a trigger and a read arrive in the same cycle.
- R5: A trigger arriving while `pend_o` is 16 is dropped and increments `skip_o`, which saturates at 15.
- R6: Record layout: bits [15:12] skip count, [11:8] low 4 bits of the trigger identifier, [7:0] `bcid_o` as it stood in the trigger's cycle.
- R7: An accepted trigger arriving at `pend_o` = 15 with no read in that cycle is not queued at once. Its record enters the queue on the next effective read and carries `skip_o` as it stands in that read's cycle.
- R8: Whenever a record enters the queue, `skip_o` restarts at 0, or at 1 if a trigger is dropped in that same cycle.
- R9: `ecr_i` clears `l1id_o`, `pend_o`, `skip_o`, the burst window, the held record and the queue on the next edge. A trigger or read in the same cycle is ignored. `bcid_o` is not affected.
- R10: After reset every counter output is 0 and `rec_valid_o` is low.
- R11: A read strobe while `rec_valid_o` is low changes nothing.
- R12: Records leave the queue in the order they entered. `rec_o` shows the oldest record whenever `rec_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Decoded trigger pulse |
| bcr_i | input | 1 | Bunch-counter reset pulse |
| ecr_i | input | 1 | Event-counter reset pulse |
| contig_i | input | 4 | Extra triggers per burst sharing one identifier (0..15) |
| rd_i | input | 1 | Event-builder read strobe, pops the oldest record |
| rec_valid_o | output | 1 | Queue holds at least one record |
| rec_o | output | 16 | Oldest queued record |
| bcid_o | output | 8 | Bunch-crossing counter |
| l1id_o | output | 8 | Trigger identifier counter |
| pend_o | output | 5 | Accepted events not yet read (0..16) |
| skip_o | output | 4 | Dropped triggers since the last stored record |

## Verification
Every result here is due exactly one edge after its stimulus: counters, queue head and valid flag are all registered once, with no pipeline. Inputs are driven on the falling edge, and a behavioural model (integers and a queue) advances in that same step. All outputs are compared on the next falling edge, so each comparison falls in the first cycle where the answer is due. Directed phases cover the exact fill to 15 and 16, saturation of the loss count, the deferred record, bursts and mid-stream resets. Random traffic then mixes triggers and reads that coincide.

// File: rtl/l1t_pkg.sv
package l1t_pkg;
  localparam int REC_SKIP_W = 4;
  localparam int REC_ID_W   = 4;
  localparam int REC_BX_W   = 8;
  localparam int REC_W      = REC_SKIP_W + REC_ID_W + REC_BX_W;

  typedef struct packed {
    logic [REC_SKIP_W-1:0] skip;
    logic [REC_ID_W-1:0]   id;
    logic [REC_BX_W-1:0]   bx;
  } evt_rec_t;

  function automatic evt_rec_t make_rec(input logic [REC_SKIP_W-1:0] s,
                                        input logic [REC_ID_W-1:0] i,
                                        input logic [REC_BX_W-1:0] b);
    evt_rec_t r;
    r.skip = s;
    r.id   = i;
    r.bx   = b;
    return r;
  endfunction
endpackage

// File: rtl/l1t_timebase.sv
module l1t_timebase #(
  parameter int BX_W = 8,
  parameter int ID_W = 8,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            bcr,
  input  logic            ecr,
  input  logic [CW-1:0]   contig_cfg,
  output logic [BX_W-1:0] bcid,
  output logic [ID_W-1:0] l1id,
  output logic [ID_W-1:0] evt_id,
  output logic            burst_start
);
  logic [CW-1:0] window_q;
  logic          in_window;

  assign in_window   = (window_q != '0);
  assign burst_start = trig && !ecr && !in_window;
  // a trigger inside a window belongs to the burst already counted
  assign evt_id      = burst_start ? l1id : ID_W'(l1id - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcid     <= '0;
      l1id     <= '0;
      window_q <= '0;
    end else begin
      bcid <= bcr ? '0 : BX_W'(bcid + 1'b1);
      if (ecr) begin
        l1id     <= '0;
        window_q <= '0;
      end else if (burst_start) begin
        l1id     <= ID_W'(l1id + 1'b1);
        window_q <= contig_cfg;
      end else if (in_window) begin
        window_q <= CW'(window_q - 1'b1);
      end
    end
  end

  a_r1_bcid_step: assert property (@(posedge clk) disable iff (!rst_n)
    !bcr |=> bcid == BX_W'($past(bcid) + 1'b1));
  a_r1_bcr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    bcr |=> bcid == '0);
  a_r2_id_step: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> l1id == ID_W'($past(l1id) + 1'b1));
  a_r3_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !ecr && in_window) |=> l1id == $past(l1id));
endmodule

// File: rtl/l1t_skip_count.sv
module l1t_skip_count #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drop,
  input  logic          stored,
  input  logic          ecr,
  output logic [SW-1:0] skip
);
  localparam logic [SW-1:0] SKIP_MAX = '1;

  function automatic logic [SW-1:0] sat_inc(input logic [SW-1:0] v);
    return (v == SKIP_MAX) ? v : SW'(v + 1'b1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || ecr)  skip <= '0;
    else if (stored)    skip <= drop ? SW'(1) : '0;
    else if (drop)      skip <= sat_inc(skip);
  end

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (skip == SKIP_MAX && !stored && !ecr) |=> skip == SKIP_MAX);
  a_r5_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !stored && !ecr && skip != SKIP_MAX) |=> skip == SW'($past(skip) + 1'b1));
endmodule

// File: rtl/l1t_evt_fifo.sv
module l1t_evt_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           push,
  input  logic [W-1:0]   din,
  input  logic           pop,
  output logic [W-1:0]   dout,
  output logic           nonempty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + 1'b1);
  endfunction

  assign dout     = mem[rp];
  assign nonempty = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop)      cnt <= CW'(cnt + 1'b1);
      else if (pop && !push) cnt <= CW'(cnt - 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> (cnt < CW'(DEPTH) || pop));
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);
endmodule

// File: rtl/l1_trigger_keeper.sv
module l1_trigger_keeper
  import l1t_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BX_W  = REC_BX_W,
  parameter int ID_W  = 8,
  parameter int CW    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          trig_i,
  input  logic                          bcr_i,
  input  logic                          ecr_i,
  input  logic [CW-1:0]                 contig_i,
  input  logic                          rd_i,
  output logic                          rec_valid_o,
  output logic [REC_W-1:0]              rec_o,
  output logic [BX_W-1:0]               bcid_o,
  output logic [ID_W-1:0]               l1id_o,
  output logic [$clog2(DEPTH+1)-1:0]    pend_o,
  output logic [REC_SKIP_W-1:0]         skip_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] P_FULL  = PW'(DEPTH);
  localparam logic [PW-1:0] P_AFULL = PW'(DEPTH - 1);

  logic [PW-1:0]   pend_q;
  logic [ID_W-1:0] evt_id;
  logic            burst_start;
  logic            t_ok, full, afull, rd_ok;
  logic            accept, drop, defer, release_hold, direct, rec_wr;
  logic            hold_v;
  logic [REC_ID_W-1:0] hold_id;
  logic [REC_BX_W-1:0] hold_bx;
  evt_rec_t        wr_rec;

  l1t_timebase #(.BX_W(BX_W), .ID_W(ID_W), .CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .trig(trig_i), .bcr(bcr_i), .ecr(ecr_i),
    .contig_cfg(contig_i), .bcid(bcid_o), .l1id(l1id_o),
    .evt_id(evt_id), .burst_start(burst_start)
  );

  // event decisions, brought out as named wires
  assign t_ok         = trig_i && !ecr_i;
  assign full         = (pend_q == P_FULL);
  assign afull        = (pend_q == P_AFULL);
  assign rd_ok        = rd_i && rec_valid_o && !ecr_i;
  assign accept       = t_ok && !full;
  assign drop         = t_ok && full;
  assign defer        = accept && afull && !rd_ok;
  assign release_hold = hold_v && rd_ok;
  assign direct       = accept && !defer;
  assign rec_wr       = direct || release_hold;

  assign wr_rec = release_hold ? make_rec(skip_o, hold_id, hold_bx)
                               : make_rec(skip_o, evt_id[REC_ID_W-1:0], bcid_o[REC_BX_W-1:0]);

  l1t_skip_count #(.SW(REC_SKIP_W)) u_skip (
    .clk(clk), .rst_n(rst_n), .drop(drop), .stored(rec_wr),
    .ecr(ecr_i), .skip(skip_o)
  );

  l1t_evt_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(ecr_i), .push(rec_wr), .din(wr_rec),
    .pop(rd_ok), .dout(rec_o), .nonempty(rec_valid_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || ecr_i) begin
      pend_q <= '0;
      hold_v <= 1'b0;
    end else begin
      if (accept && !rd_ok)      pend_q <= PW'(pend_q + 1'b1);
      else if (rd_ok && !accept) pend_q <= PW'(pend_q - 1'b1);
      if (defer)             hold_v <= 1'b1;
      else if (release_hold) hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (defer) begin
      hold_id <= evt_id[REC_ID_W-1:0];
      hold_bx <= bcid_o[REC_BX_W-1:0];
    end
  end

  assign pend_o = pend_q;

  a_r4_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= P_FULL);
  a_r4_pair_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && rd_i && !ecr_i && pend_q != '0 && !full) |=> pend_q == $past(pend_q));
  a_r5_drop_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !rd_i) |=> pend_q == P_FULL);
  a_r7_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !rd_i && !ecr_i) |=> hold_v);
  a_r8_skip_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_wr && !drop && !ecr_i) |=> skip_o == '0);
  a_r9_ecr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ecr_i |=> (pend_q == '0 && !rec_valid_o && l1id_o == '0 && skip_o == '0));
endmodule

// File: tb/l1_trigger_keeper_test.sv
module l1_trigger_keeper_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_i = 0, bcr_i = 0, ecr_i = 0, rd_i = 0;
  logic [3:0] contig_i = 0;
  logic rec_valid_o;
  logic [15:0] rec_o;
  logic [7:0] bcid_o, l1id_o;
  logic [4:0] pend_o;
  logic [3:0] skip_o;

  int n_checks = 0;
  int n_fail = 0;

  // behavioural reference state
  int m_bx = 0, m_id = 0, m_win = 0, m_pend = 0, m_skip = 0;
  bit m_hold = 0;
  int m_hold_rec = 0;
  int m_q[$];

  always #10 clk = ~clk;

  l1_trigger_keeper uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .bcr_i(bcr_i), .ecr_i(ecr_i),
    .contig_i(contig_i), .rd_i(rd_i), .rec_valid_o(rec_valid_o), .rec_o(rec_o),
    .bcid_o(bcid_o), .l1id_o(l1id_o), .pend_o(pend_o), .skip_o(skip_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 bcid", int'(bcid_o), m_bx);
    chk("R2 l1id", int'(l1id_o), m_id);
    chk("R4 pending", int'(pend_o), m_pend);
    chk("R5 skip", int'(skip_o), m_skip);
    chk("R11 valid", int'(rec_valid_o), int'(m_q.size() > 0));
    if (m_q.size() > 0) chk("R6 record", int'(rec_o), m_q[0]);
  endtask

  // one cycle of the reference, from the rules in the requirements
  task automatic model(input bit t, input bit b, input bit e, input int cfg, input bit r);
    int tid, rec;
    bit start, rdok, acc, rej, wrote;
    if (e) begin
      m_id = 0; m_win = 0; m_pend = 0; m_skip = 0; m_hold = 0;
      m_q.delete();
    end else begin
      start = t && m_win == 0;
      tid   = start ? m_id : (m_id + 255) % 256;
      rdok  = r && m_q.size() > 0;
      acc   = t && m_pend < 16;
      rej   = t && m_pend == 16;
      wrote = 0;
      if (rdok) void'(m_q.pop_front());
      if (m_hold && rdok) begin
        m_q.push_back(m_skip * 4096 + m_hold_rec);
        m_hold = 0; wrote = 1;
      end else if (acc) begin
        rec = (tid % 16) * 256 + m_bx;
        if (m_pend == 15 && !rdok) begin
          m_hold = 1; m_hold_rec = rec;
        end else begin
          m_q.push_back(m_skip * 4096 + rec); wrote = 1;
        end
      end
      if (wrote) m_skip = rej ? 1 : 0;
      else if (rej && m_skip < 15) m_skip++;
      m_pend = m_pend + int'(acc) - int'(rdok);
      if (start) begin m_id = (m_id + 1) % 256; m_win = cfg; end
      else if (m_win > 0) m_win--;
    end
    m_bx = b ? 0 : (m_bx + 1) % 256;
  endtask

  task automatic cyc(input bit t, input bit b, input bit e, input int cfg, input bit r);
    trig_i = t; bcr_i = b; ecr_i = e; contig_i = 4'(cfg); rd_i = r;
    model(t, b, e, cfg, r);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int first_rec;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_bx = 1;  // one edge counted since reset release
    // R10: everything zero out of reset
    chk("R10 l1id", int'(l1id_o), 0);
    chk("R10 pending", int'(pend_o), 0);
    chk("R10 skip", int'(skip_o), 0);
    chk("R10 valid", int'(rec_valid_o), 0);
    compare_all();

    // R11: read of an empty queue has no effect
    cyc(0, 0, 0, 0, 1);
    chk("R11 empty read pending", int'(pend_o), 0);

    // single trigger then read it
    cyc(1, 0, 0, 0, 0);
    chk("R6 single record id/bx", int'(rec_o), m_q[0]);
    cyc(0, 0, 0, 0, 1);

    // R3: burst of four sharing one identifier
    cyc(1, 0, 0, 3, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 3, 0);
    cyc(0, 0, 0, 3, 0);
    chk("R3 burst one id step", int'(l1id_o), 2);
    first_rec = int'(rec_o);
    cyc(0, 0, 0, 0, 1);
    chk("R3 burst same id field", (int'(rec_o) >> 8) & 15, (first_rec >> 8) & 15);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1);

    // R1: bunch-counter reset
    cyc(0, 1, 0, 0, 0);
    chk("R1 bcr to zero", int'(bcid_o), 0);

    // fill to 15, then the 16th is deferred (R7), then drops (R5)
    for (int i = 0; i < 16; i++) cyc(1, 0, 0, 0, 0);
    chk("R4 full at 16", int'(pend_o), 16);
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 0);
    chk("R5 skip saturated", int'(skip_o), 15);
    // R12: drain in order; the deferred record appears with skip 15
    for (int i = 0; i < 16; i++) begin
      cyc(0, 0, 0, 0, 1);
      if (i == 14) chk("R7 deferred record skip", int'(rec_o) >> 12, 15);
    end
    chk("R8 skip restarted", int'(skip_o), 0);

    // R9: event-counter reset with a trigger in the same cycle
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 1);
    chk("R9 ecr pending", int'(pend_o), 0);
    chk("R9 ecr l1id", int'(l1id_o), 0);
    chk("R9 ecr valid", int'(rec_valid_o), 0);

    // random traffic with coincident triggers and reads
    for (int i = 0; i < 4000; i++) begin
      int p = $urandom_range(0, 99);
      cyc(p < 55, $urandom_range(0, 199) == 0, $urandom_range(0, 499) == 0,
          ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : 0,
          $urandom_range(0, 99) < ((i / 500) % 2 ? 30 : 60));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule